// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller with Spurious Fallback

This block gathers eight interrupt request lines, lets software mask each one, and drives one level interrupt output toward a processor. Line 0 has the highest fixed priority and line 7 the lowest. A new request raises the output only when it outranks every line already being serviced, so higher-priority work can nest over lower-priority work.

The processor acknowledges with two strobes on one input. The first strobe freezes the winning line. The second strobe returns an 8-bit vector and marks that line in service. If the frozen line has gone away by the second strobe, the handshake still completes: the controller returns the vector of line 7, marks nothing in service, and adds one to a saturating spurious counter. An end-of-interrupt command written through the register port clears an in-service bit. The command either names the line or picks the highest-priority one in service.

Requests pass through a two-flop synchronizer. In edge mode a rising edge latches a request, which stays until it is acknowledged. In level mode the request follows the line, so a line that drops before the acknowledge is withdrawn.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output and vector-valid are low. The mask register reads 0xFF (all lines masked). The configuration, in-service and spurious-count registers read 0.
- R2: A line whose mask bit (register 0, bit n masks line n) is 1 never raises the interrupt output. Clearing the bit lets a pending request raise the output within a few cycles.
- R3: Among pending unmasked requests, the lowest line number is delivered.
- R4: The delivered vector is the 5-bit base from register 1 bits 7:3, followed by the 3-bit line number in bits 2:0.
- R5: The first acknowledge strobe produces no vector. The second always produces vector-valid for exactly one cycle, in the cycle after that strobe.
- R6: A genuine acknowledge sets the line's in-service bit (register 2 reads the in-service set, bit n for line n). The output stays low while no pending line outranks every in-service line. A request of higher priority raises it again.
- R7: Writing register 2 with bit 6 set clears the in-service bit of the line given in bits 2:0. Writing it with only bit 5 set clears the highest-priority in-service bit.
- R8: If the line frozen by the first strobe is no longer pending at the second strobe, the vector is base with line 7. No in-service bit is set, and the spurious count in register 3 rises by one. The same applies when no line was pending at the first strobe.
- R9: The spurious count stops at 255.
- R10: In edge mode (register 1 bit 0 = 0), a request is latched on a rising edge and survives the line dropping. A line held high makes no new request after it is serviced. Masking the line and then unmasking it while it is still high makes a new request.
- R11: In level mode (register 1 bit 0 = 1), a request follows the line. A line that stays high requests again after end-of-interrupt. A line that drops is withdrawn.
- R12: The interrupt output is a level that holds until the request is acknowledged, withdrawn or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt request lines, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mask, 1 config, 2 command / in-service, 3 spurious count |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| int_out | output | 1 | Interrupt request level to the processor |
| ack_stb | input | 1 | Acknowledge strobe; two strobes make one handshake |
| vec_out | output | 8 | Delivered vector |
| vec_vld | output | 1 | One-cycle pulse marking vec_out valid |

## Verification
A wrong in-service set shows up at once. The interrupt output stays low when a nested higher-priority line should raise it, or it re-rises right after acknowledge. Register 2 also reads back the wrong bits in the next cycle.

A frozen-line or phase error appears on the next acknowledge. The vector carries the wrong line number, or the valid pulse arrives after the first strobe or fails to arrive after the second. The spurious path is driven by dropping a level request between the two strobes, so that the count and the unchanged in-service set can be read back. An edge-capture fault appears as a missing or extra request once the line stays high after end-of-interrupt.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int REG_AW = 2;
    localparam int DATA_W = 8;

    localparam logic [REG_AW-1:0] ADDR_MASK = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_CFG  = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_CMD  = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_SPUR = 2'd3;

    localparam int CMD_EOI_BIT  = 5;
    localparam int CMD_SPEC_BIT = 6;

    typedef enum logic {
        ACK_IDLE,
        ACK_HOLD
    } ack_phase_e;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic               level_mode,
    input  logic [NUM_IRQ-1:0] ack_clr,
    output logic [NUM_IRQ-1:0] irr
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] sync1;
        logic [NUM_IRQ-1:0] sync2;
        logic [NUM_IRQ-1:0] gprev;
        logic [NUM_IRQ-1:0] irr;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [NUM_IRQ-1:0] gated;
    logic [NUM_IRQ-1:0] rise;
    logic [NUM_IRQ-1:0] irr_next;

    assign gated = cap_q.sync2 & ~mask;
    assign rise  = gated & ~cap_q.gprev;

    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_line
        assign irr_next[gi] = level_mode ? gated[gi]
                                         : ((cap_q.irr[gi] & ~ack_clr[gi]) | rise[gi]);
    end

    always_comb begin
        cap_d       = cap_q;
        cap_d.sync1 = irq_in;
        cap_d.sync2 = cap_q.sync1;
        cap_d.gprev = gated;
        cap_d.irr   = irr_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign irr = cap_q.irr;

    AST_EDGE_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!level_mode && $past(!level_mode) && ($past(ack_clr) == '0)) |-> ((cap_q.irr & $past(cap_q.irr)) == $past(cap_q.irr))); // R10

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
    parameter int NUM_IRQ = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0] irr,
    input  logic [NUM_IRQ-1:0] mask,
    input  logic [NUM_IRQ-1:0] isr,
    output logic [NUM_IRQ-1:0] eff,
    output logic               int_req,
    output logic [IDX_W-1:0]   win_idx,
    output logic               isr_any,
    output logic [IDX_W-1:0]   isr_idx
);

    logic eff_any;

    assign eff = irr & ~mask;

    always_comb begin
        win_idx = '0;
        eff_any = 1'b0;
        isr_idx = '0;
        isr_any = 1'b0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (eff[i]) begin
                win_idx = IDX_W'(i);
                eff_any = 1'b1;
            end
            if (isr[i]) begin
                isr_idx = IDX_W'(i);
                isr_any = 1'b1;
            end
        end
        int_req = eff_any && (!isr_any || (win_idx < isr_idx));
    end

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int CNT_W   = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int BASE_W = DATA_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_stb,
    input  logic               int_req,
    input  logic [IDX_W-1:0]   win_idx,
    input  logic [NUM_IRQ-1:0] eff,
    input  logic [BASE_W-1:0]  base,
    input  logic               eoi_stb,
    input  logic               eoi_spec,
    input  logic [IDX_W-1:0]   eoi_idx,
    input  logic               isr_any,
    input  logic [IDX_W-1:0]   isr_idx,
    output logic [NUM_IRQ-1:0] isr,
    output logic [DATA_W-1:0]  vec,
    output logic               vec_vld,
    output logic [CNT_W-1:0]   spur_cnt,
    output logic [NUM_IRQ-1:0] ack_clr
);

    localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(NUM_IRQ - 1);
    localparam logic [NUM_IRQ-1:0] ONE_HOT0 = NUM_IRQ'(1);
    localparam logic [CNT_W-1:0]   CNT_MAX  = '1;

    typedef struct packed {
        ack_phase_e         phase;
        logic               frz_vld;
        logic [IDX_W-1:0]   frz_idx;
        logic [NUM_IRQ-1:0] isr;
        logic [DATA_W-1:0]  vec;
        logic               vec_vld;
        logic [CNT_W-1:0]   spur;
    } ack_t;

    ack_t ack_d, ack_q;
    logic               hit;
    logic [NUM_IRQ-1:0] set_bits;
    logic [NUM_IRQ-1:0] clr_bits;

    always_comb begin
        ack_d         = ack_q;
        ack_d.vec_vld = 1'b0;
        hit           = 1'b0;
        set_bits      = '0;
        clr_bits      = '0;

        if (eoi_stb) begin
            if (eoi_spec)     clr_bits = ONE_HOT0 << eoi_idx;
            else if (isr_any) clr_bits = ONE_HOT0 << isr_idx;
        end

        if (ack_stb) begin
            if (ack_q.phase == ACK_IDLE) begin
                ack_d.phase   = ACK_HOLD;
                ack_d.frz_vld = int_req;
                ack_d.frz_idx = win_idx;
            end else begin
                ack_d.phase   = ACK_IDLE;
                ack_d.vec_vld = 1'b1;
                hit           = ack_q.frz_vld && eff[ack_q.frz_idx];
                if (hit) begin
                    ack_d.vec = {base, ack_q.frz_idx};
                    set_bits  = ONE_HOT0 << ack_q.frz_idx;
                end else begin
                    ack_d.vec = {base, LAST_IDX};
                    if (ack_q.spur != CNT_MAX) ack_d.spur = ack_q.spur + CNT_W'(1);
                end
            end
        end

        ack_d.isr = (ack_q.isr & ~clr_bits) | set_bits;
        ack_clr   = set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= '{phase: ACK_IDLE, default: '0};
        else        ack_q <= ack_d;
    end

    assign isr      = ack_q.isr;
    assign vec      = ack_q.vec;
    assign vec_vld  = ack_q.vec_vld;
    assign spur_cnt = ack_q.spur;

    AST_ACK_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n) (ack_q.phase == ACK_HOLD && ack_stb) |=> ack_q.vec_vld); // R5
    AST_FIRST_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n) (ack_q.phase == ACK_IDLE && ack_stb) |=> !ack_q.vec_vld); // R5
    AST_SPUR_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n) (ack_q.phase == ACK_HOLD && ack_stb && !hit && !eoi_stb) |=> $stable(ack_q.isr)); // R8
    AST_SPUR_STEP: assert property (@(posedge clk) disable iff (!rst_n) (ack_q.spur != $past(ack_q.spur)) |-> (ack_q.vec_vld && ack_q.spur == $past(ack_q.spur) + CNT_W'(1))); // R8
    AST_SPUR_SAT: assert property (@(posedge clk) disable iff (!rst_n) ($past(ack_q.spur) == CNT_MAX) |-> (ack_q.spur == CNT_MAX)); // R9

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_IRQ = 8,
    parameter int CNT_W   = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int BASE_W = DATA_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               int_out,
    input  logic               ack_stb,
    output logic [DATA_W-1:0]  vec_out,
    output logic               vec_vld
);

    typedef struct packed {
        logic [NUM_IRQ-1:0] mask;
        logic [BASE_W-1:0]  base;
        logic               level;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NUM_IRQ-1:0] irr;
    logic [NUM_IRQ-1:0] eff;
    logic [NUM_IRQ-1:0] isr;
    logic [NUM_IRQ-1:0] ack_clr;
    logic               int_req;
    logic [IDX_W-1:0]   win_idx;
    logic               isr_any;
    logic [IDX_W-1:0]   isr_idx;
    logic [CNT_W-1:0]   spur_cnt;
    logic               eoi_stb;
    logic               eoi_spec;
    logic [IDX_W-1:0]   eoi_idx;

    always_comb begin
        regs_d = regs_q;
        if (reg_we) begin
            unique case (reg_addr)
                ADDR_MASK: regs_d.mask = reg_wdata[NUM_IRQ-1:0];
                ADDR_CFG: begin
                    regs_d.base  = reg_wdata[DATA_W-1:IDX_W];
                    regs_d.level = reg_wdata[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{mask: '1, default: '0};
        else        regs_q <= regs_d;
    end

    assign eoi_stb  = reg_we && (reg_addr == ADDR_CMD)
                      && (reg_wdata[CMD_EOI_BIT] || reg_wdata[CMD_SPEC_BIT]);
    assign eoi_spec = reg_wdata[CMD_SPEC_BIT];
    assign eoi_idx  = reg_wdata[IDX_W-1:0];

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_MASK: reg_rdata = DATA_W'(regs_q.mask);
            ADDR_CFG: begin
                reg_rdata[DATA_W-1:IDX_W] = regs_q.base;
                reg_rdata[0]              = regs_q.level;
            end
            ADDR_CMD:  reg_rdata = DATA_W'(isr);
            default:   reg_rdata = DATA_W'(spur_cnt);
        endcase
    end

    irq_req_capture #(.NUM_IRQ(NUM_IRQ)) i_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .mask       (regs_q.mask),
        .level_mode (regs_q.level),
        .ack_clr    (ack_clr),
        .irr        (irr)
    );

    irq_prio_resolve #(.NUM_IRQ(NUM_IRQ)) i_resolve (
        .irr     (irr),
        .mask    (regs_q.mask),
        .isr     (isr),
        .eff     (eff),
        .int_req (int_req),
        .win_idx (win_idx),
        .isr_any (isr_any),
        .isr_idx (isr_idx)
    );

    irq_ack_ctrl #(.NUM_IRQ(NUM_IRQ), .CNT_W(CNT_W)) i_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_stb  (ack_stb),
        .int_req  (int_req),
        .win_idx  (win_idx),
        .eff      (eff),
        .base     (regs_q.base),
        .eoi_stb  (eoi_stb),
        .eoi_spec (eoi_spec),
        .eoi_idx  (eoi_idx),
        .isr_any  (isr_any),
        .isr_idx  (isr_idx),
        .isr      (isr),
        .vec      (vec_out),
        .vec_vld  (vec_vld),
        .spur_cnt (spur_cnt),
        .ack_clr  (ack_clr)
    );

    assign int_out = int_req;

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (regs_q.mask == '1) |-> !int_out); // R2
    AST_VEC_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n) vec_vld |-> $past(ack_stb)); // R5

endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       int_out;
    logic       ack_stb = 1'b0;
    logic [7:0] vec_out;
    logic       vec_vld;

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .int_out   (int_out),
        .ack_stb   (ack_stb),
        .vec_out   (vec_out),
        .vec_vld   (vec_vld)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic strobe();
        @(negedge clk);
        ack_stb = 1'b1;
        @(negedge clk);
        ack_stb = 1'b0;
    endtask

    task automatic second_strobe(output logic [7:0] v, output logic vld);
        strobe();
        v = vec_out;
        vld = vec_vld;
    endtask

    task automatic ack(input string req, output logic [7:0] v);
        logic vld;
        strobe();
        check({req, " R5 no vector after first strobe"}, 32'(vec_vld), 32'd0);
        @(negedge clk);
        second_strobe(v, vld);
        check({req, " R5 vector valid after second strobe"}, 32'(vld), 32'd1);
        @(negedge clk);
        check({req, " R5 vector valid lasts one cycle"}, 32'(vec_vld), 32'd0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 int_out", 32'(int_out), 32'd0);
        check("R1 vec_vld", 32'(vec_vld), 32'd0);
        rd(2'd0, d); check("R1 mask", 32'(d), 32'hFF);
        rd(2'd1, d); check("R1 cfg", 32'(d), 32'h00);
        rd(2'd2, d); check("R1 isr", 32'(d), 32'h00);
        rd(2'd3, d); check("R1 spur", 32'(d), 32'h00);
    endtask

    task automatic t_mask_level();
        logic [7:0] v, d;
        wr(2'd1, 8'hA9);
        irq_in = 8'h01;
        cycles(6);
        check("R2 masked line stays quiet", 32'(int_out), 32'd0);
        wr(2'd0, 8'hFE);
        cycles(3);
        check("R2 unmask raises int_out", 32'(int_out), 32'd1);
        cycles(20);
        check("R12 int_out held", 32'(int_out), 32'd1);
        ack("R3", v);
        check("R4 vector base and line 0", 32'(v), 32'hA8);
        rd(2'd2, d); check("R6 isr line 0", 32'(d), 32'h01);
        check("R6 serviced line keeps int_out low", 32'(int_out), 32'd0);
        wr(2'd2, 8'h20);
        cycles(2);
        check("R11 level line requests again after EOI", 32'(int_out), 32'd1);
        ack("R11", v);
        check("R11 vector line 0", 32'(v), 32'hA8);
        wr(2'd2, 8'h20);
        irq_in = 8'h00;
        cycles(5);
        check("R11 dropped level line withdrawn", 32'(int_out), 32'd0);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_spurious();
        logic [7:0] v, d;
        logic vld;
        wr(2'd0, 8'hF7);
        irq_in = 8'h08;
        cycles(5);
        check("R8 setup int_out", 32'(int_out), 32'd1);
        strobe();
        irq_in = 8'h00;
        cycles(6);
        second_strobe(v, vld);
        check("R8 spurious still completes", 32'(vld), 32'd1);
        check("R8 spurious vector is line 7", 32'(v), 32'hAF);
        rd(2'd2, d); check("R8 no isr on spurious", 32'(d), 32'h00);
        rd(2'd3, d); check("R8 spurious count 1", 32'(d), 32'h01);
        ack("R8", v);
        check("R8 empty ack gives line 7", 32'(v), 32'hAF);
        rd(2'd3, d); check("R8 spurious count 2", 32'(d), 32'h02);
        wr(2'd0, 8'hFF);
    endtask

    task automatic t_saturate();
        logic [7:0] v, d;
        logic vld;
        for (int i = 0; i < 260; i++) begin
            strobe();
            second_strobe(v, vld);
        end
        rd(2'd3, d); check("R9 spurious count saturates", 32'(d), 32'hFF);
    endtask

    task automatic t_priority_edge();
        logic [7:0] v, d;
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h00);
        irq_in = 8'h24;
        cycles(2);
        irq_in = 8'h00;
        cycles(5);
        check("R10 edge request latched after drop", 32'(int_out), 32'd1);
        ack("R3", v);
        check("R3 lowest line wins", 32'(v), 32'h12);
        rd(2'd2, d); check("R6 isr line 2", 32'(d), 32'h04);
        check("R6 lower line blocked", 32'(int_out), 32'd0);
        irq_in = 8'h02;
        cycles(2);
        irq_in = 8'h00;
        cycles(5);
        check("R6 higher line nests", 32'(int_out), 32'd1);
        ack("R6", v);
        check("R4 vector line 1", 32'(v), 32'h11);
        rd(2'd2, d); check("R6 isr lines 1 and 2", 32'(d), 32'h06);
        wr(2'd2, 8'h20);
        rd(2'd2, d); check("R7 nonspecific EOI clears line 1", 32'(d), 32'h04);
        check("R7 line 5 still blocked", 32'(int_out), 32'd0);
        wr(2'd2, 8'h42);
        rd(2'd2, d); check("R7 specific EOI clears line 2", 32'(d), 32'h00);
        cycles(1);
        check("R7 line 5 now raises", 32'(int_out), 32'd1);
        ack("R3", v);
        check("R4 vector line 5", 32'(v), 32'h15);
        wr(2'd2, 8'h20);
        cycles(2);
        check("R10 acked edge request cleared", 32'(int_out), 32'd0);
    endtask

    task automatic t_edge_retrigger();
        logic [7:0] v;
        irq_in = 8'h10;
        cycles(5);
        check("R10 edge line 4 raises", 32'(int_out), 32'd1);
        ack("R10", v);
        check("R10 vector line 4", 32'(v), 32'h14);
        wr(2'd2, 8'h20);
        cycles(5);
        check("R10 held line gives no new request", 32'(int_out), 32'd0);
        wr(2'd0, 8'h10);
        wr(2'd0, 8'h00);
        cycles(3);
        check("R10 mask toggle makes new request", 32'(int_out), 32'd1);
        ack("R10", v);
        check("R10 retrigger vector line 4", 32'(v), 32'h14);
        wr(2'd2, 8'h20);
        irq_in = 8'h00;
        wr(2'd0, 8'hFF);
        cycles(3);
        check("R2 all masked quiet at end", 32'(int_out), 32'd0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_mask_level();
        t_spurious();
        t_saturate();
        t_priority_edge();
        t_edge_retrigger();
        summary();
        $finish;
    end

endmodule